// File: doc/BRIEF.md
# Dual-Mode Delay Setting Register

This block stores the delay code that steers a programmable timing element. A mode pin picks how the code is written. With the pin low, an 8-bit parallel word goes through a latch. The latch is transparent while the load strobe is high and holds its value while the strobe is low. With the pin high, a three-wire serial port fills an internal shift register, most significant bit first. The new value becomes the active code only when the load strobe falls. A serial output carries the bit leaving the shift register, so several parts can share one chain. The same output also lets a host read the stored word back.

The active code is a plain output that feeds the delay core. The control pins are sampled on the system clock: a register stage, then edge detection. Every change to the active code clears a ready flag. The flag returns after a settling time, given in system clocks, taken from an input. After reset the shift register and the active code are zero, and the ready flag is high.

Top module: `delay_code_reg`

## Requirements
- R1: While `rstN` is low, `activeCode` is 0, `serOut` is 0 and `codeReady` is 1.
- R2: With `serialMode` low and `latchEn` high, `activeCode` takes the value of `parData` two system clocks after `parData` changes. Both inputs pass through one register stage.
- R3: With `serialMode` low and `latchEn` low, changes on `parData` leave `activeCode` unchanged.
- R4: With `serialMode` high and `latchEn` high, each rising edge of `serClk` shifts the shift register left by one. The `serData` value enters at bit 0, so the first bit sent ends up as bit 7 after eight edges.
- R5: In serial mode, a falling edge of `latchEn` copies the shift register into `activeCode`.
- R6: In serial mode, `activeCode` does not change while bits are shifted in.
- R7: `serOut` equals bit 7 of the shift register. Eight shifts therefore present the old word on `serOut` one bit at a time, most significant bit first.
- R8: Eight shifts with `serData` held opposite to the stored bits replace the stored word, so the read destroys it. Feeding `serOut` back into `serData` leaves the word intact.
- R9: When `activeCode` changes, `codeReady` is 0 in that same cycle. It returns to 1 exactly `settleCycles` system clocks later, and any further change restarts the count.
- R10: When `settleCycles` is 0, `codeReady` stays 1 across code changes.
- R11: In serial mode `parData` has no effect. In parallel mode `serClk` edges do not move the shift register.
- R12: In serial mode, `serClk` edges while `latchEn` is low do not move the shift register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| serialMode | input | 1 | 0 selects parallel mode, 1 selects serial mode |
| latchEn | input | 1 | Load strobe: transparent-latch enable, or serial enable and commit |
| serClk | input | 1 | Serial shift clock, sampled on `clk` |
| serData | input | 1 | Serial data in |
| parData | input | CODE_W | Parallel code in |
| settleCycles | input | CNT_W | Settling time in system clocks |
| serOut | output | 1 | Serial data out (shift register MSB) |
| activeCode | output | CODE_W | Code presented to the delay core |
| codeReady | output | 1 | High once the settling time has elapsed |

## Verification
The assertions assume that all pins change well apart from the system clock edge. They also assume that each level on `serClk` and `latchEn` lasts at least two system clocks, so that every serial edge turns into exactly one sampled strobe. The bench drives every input on the falling clock edge and holds each serial clock level and strobe level for three cycles. It changes `serialMode` only while `latchEn` is low, so a mode switch never looks like a commit or a parallel load. Random words are sent through both ports and compared with a bench model of the shift register and the active code.

// File: rtl/dcr_pkg.sv
package dcr_pkg;
  // strobes from control to datapath, at most one per cycle
  typedef struct packed {
    logic shiftEn;
    logic commitEn;
    logic parLoadEn;
  } dcrStrobeT;
endpackage

// File: rtl/dcr_ctrl.sv
module dcr_ctrl
  import dcr_pkg::*;
#(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serialMode,
  input  logic              latchEn,
  input  logic              serClk,
  input  logic              serData,
  input  logic [CODE_W-1:0] parData,
  output dcrStrobeT         stb,
  output logic              serDataQ,
  output logic [CODE_W-1:0] parDataQ
);
  logic modeQ, leQ, leQPrev, sclkQ, sclkQPrev;

  // one sampling stage for every pin, plus history for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ     <= 1'b0;
      leQ       <= 1'b0;
      leQPrev   <= 1'b0;
      sclkQ     <= 1'b0;
      sclkQPrev <= 1'b0;
      serDataQ  <= 1'b0;
      parDataQ  <= '0;
    end else begin
      modeQ     <= serialMode;
      leQ       <= latchEn;
      leQPrev   <= leQ;
      sclkQ     <= serClk;
      sclkQPrev <= sclkQ;
      serDataQ  <= serData;
      parDataQ  <= parData;
    end
  end

  always_comb begin
    stb           = '0;
    stb.shiftEn   = modeQ & leQ & sclkQ & ~sclkQPrev;
    stb.commitEn  = modeQ & ~leQ & leQPrev;
    stb.parLoadEn = ~modeQ & leQ;
  end
endmodule

// File: rtl/dcr_datapath.sv
module dcr_datapath
  import dcr_pkg::*;
#(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dcrStrobeT         stb,
  input  logic              serDataQ,
  input  logic [CODE_W-1:0] parDataQ,
  output logic [CODE_W-1:0] shiftReg,
  output logic [CODE_W-1:0] activeCode,
  output logic              codeChange
);
  logic [CODE_W-1:0] codeNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shiftReg <= '0;
    else if (stb.shiftEn) shiftReg <= {shiftReg[CODE_W-2:0], serDataQ};
  end

  always_comb begin
    codeNext = activeCode;
    if (stb.commitEn)       codeNext = shiftReg;
    else if (stb.parLoadEn) codeNext = parDataQ;
  end

  assign codeChange = (codeNext != activeCode);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) activeCode <= '0;
    else       activeCode <= codeNext;
  end
endmodule

// File: rtl/dcr_settle.sv
module dcr_settle #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             codeChange,
  input  logic [CNT_W-1:0] settleCycles,
  output logic             codeReady
);
  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             remain <= '0;
    else if (codeChange)   remain <= settleCycles;
    else if (remain != '0) remain <= remain - 1'b1;
  end

  assign codeReady = (remain == '0);
endmodule

// File: rtl/delay_code_reg.sv
module delay_code_reg
  import dcr_pkg::*;
#(
  parameter int CODE_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serialMode,
  input  logic              latchEn,
  input  logic              serClk,
  input  logic              serData,
  input  logic [CODE_W-1:0] parData,
  input  logic [CNT_W-1:0]  settleCycles,
  output logic              serOut,
  output logic [CODE_W-1:0] activeCode,
  output logic              codeReady
);
  dcrStrobeT         stb;
  logic              serDataQ;
  logic [CODE_W-1:0] parDataQ;
  logic [CODE_W-1:0] shiftReg;
  logic              codeChange;

  dcr_ctrl #(.CODE_W(CODE_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .serialMode(serialMode), .latchEn(latchEn),
    .serClk(serClk), .serData(serData), .parData(parData),
    .stb(stb), .serDataQ(serDataQ), .parDataQ(parDataQ)
  );

  dcr_datapath #(.CODE_W(CODE_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .serDataQ(serDataQ),
    .parDataQ(parDataQ), .shiftReg(shiftReg), .activeCode(activeCode),
    .codeChange(codeChange)
  );

  dcr_settle #(.CNT_W(CNT_W)) u_settle (
    .clk(clk), .rstN(rstN), .codeChange(codeChange),
    .settleCycles(settleCycles), .codeReady(codeReady)
  );

  assign serOut = shiftReg[CODE_W-1];
endmodule

// File: rtl/dcr_checker.sv
module dcr_checker
  import dcr_pkg::*;
#(
  parameter int CODE_W = 8,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rstN,
  input dcrStrobeT         stb,
  input logic [CODE_W-1:0] shiftReg,
  input logic [CODE_W-1:0] parDataQ,
  input logic [CODE_W-1:0] activeCode,
  input logic [CNT_W-1:0]  settleCycles,
  input logic              serOut,
  input logic              codeReady
);
  AST_PAR_FOLLOW: assert property (@(posedge clk) disable iff (!rstN)
    stb.parLoadEn |=> activeCode == $past(parDataQ)); // R2

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.parLoadEn || stb.commitEn) |=> $stable(activeCode)); // R3

  AST_COMMIT_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    stb.commitEn |=> activeCode == $past(shiftReg)); // R5

  AST_SHIFT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    stb.shiftEn |=> $stable(activeCode)); // R6

  AST_SHIFT_OUT: assert property (@(posedge clk) disable iff (!rstN)
    stb.shiftEn |=> serOut == $past(shiftReg[CODE_W-2])); // R7

  AST_READY_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (activeCode != $past(activeCode)) && ($past(settleCycles) != '0) |-> !codeReady); // R9

  AST_READY_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (activeCode != $past(activeCode)) && ($past(settleCycles) == '0) |-> codeReady); // R10
endmodule

bind delay_code_reg dcr_checker #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .stb(stb), .shiftReg(shiftReg), .parDataQ(parDataQ),
  .activeCode(activeCode), .settleCycles(settleCycles), .serOut(serOut),
  .codeReady(codeReady)
);

// File: tb/test_delay_code_reg.sv
`timescale 1ns/1ps
module test_delay_code_reg;
  localparam int CODE_W = 8;
  localparam int CNT_W  = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serialMode = 1'b1, latchEn = 1'b0, serClk = 1'b0, serData = 1'b0;
  logic [CODE_W-1:0] parData = '0;
  logic [CNT_W-1:0]  settleCycles = 16'd4;
  logic serOut, codeReady;
  logic [CODE_W-1:0] activeCode;

  int checks = 0, errors = 0;
  bit finished = 1'b0;
  logic [CODE_W-1:0] expShift = '0, expCode = '0;

  always #2.5 clk = ~clk;

  delay_code_reg #(.CODE_W(CODE_W), .CNT_W(CNT_W)) i_delay_code_reg (
    .clk(clk), .rstN(rstN), .serialMode(serialMode), .latchEn(latchEn),
    .serClk(serClk), .serData(serData), .parData(parData),
    .settleCycles(settleCycles), .serOut(serOut), .activeCode(activeCode),
    .codeReady(codeReady)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [CODE_W-1:0] shiftIn(input logic [CODE_W-1:0] r, input logic b);
    return {r[CODE_W-2:0], b};
  endfunction

  // one serial bit; latchEn must already be high in serial mode
  task automatic sendBit(input logic b, input string req);
    logic [CODE_W-1:0] codeBefore;
    codeBefore = activeCode;
    serData = b; serClk = 1'b1; tick(3);
    serClk = 1'b0; tick(3);
    expShift = shiftIn(expShift, b);
    check(activeCode == codeBefore, "R6", "code moved while shifting", activeCode, codeBefore);
    check(serOut == expShift[CODE_W-1], req, "serOut after shift", serOut, expShift[CODE_W-1]);
  endtask

  task automatic sendWord(input logic [CODE_W-1:0] w);
    latchEn = 1'b1; tick(3);
    for (int i = CODE_W - 1; i >= 0; i--) begin
      check(serOut == expShift[CODE_W-1], "R7", "serOut before shift", serOut, expShift[CODE_W-1]);
      sendBit(w[i], "R4");
    end
  endtask

  task automatic commit();
    latchEn = 1'b0; tick(3);
    expCode = expShift;
    check(activeCode == expCode, "R5", "code after commit", activeCode, expCode);
  endtask

  task automatic parWrite(input logic [CODE_W-1:0] w);
    parData = w; latchEn = 1'b1; tick(3);
    latchEn = 1'b0; tick(3);
    expCode = w;
    check(activeCode == expCode, "R2", "parallel load", activeCode, expCode);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(3);
    check(activeCode == 0, "R1", "code in reset", activeCode, 0);
    check(serOut == 0, "R1", "serOut in reset", serOut, 0);
    check(codeReady == 1, "R1", "ready in reset", codeReady, 1);
    rstN = 1'b1; tick(2);

    // serial write then destructive read
    sendWord(8'hA5); commit();
    tick(6);
    check(codeReady == 1, "R9", "ready after settle", codeReady, 1);
    sendWord(8'h3C); // shifting out A5 replaces it
    check(expShift == 8'h3C, "R8", "model word", expShift, 8'h3C);
    commit();
    check(activeCode == 8'h3C, "R8", "destructive read replaced", activeCode, 8'h3C);
    tick(6);

    // non-destructive read with feedback
    latchEn = 1'b1; tick(3);
    begin
      logic [CODE_W-1:0] rd;
      rd = '0;
      for (int i = 0; i < CODE_W; i++) begin
        rd = {rd[CODE_W-2:0], serOut};
        sendBit(serOut, "R7");
      end
      check(rd == 8'h3C, "R7", "read-back word", rd, 8'h3C);
    end
    commit();
    check(activeCode == 8'h3C, "R8", "feedback read keeps word", activeCode, 8'h3C);
    check(codeReady == 1, "R9", "no change keeps ready", codeReady, 1);

    // R12: serial clocks with latchEn low are ignored
    for (int i = 0; i < 3; i++) begin
      serData = ~serOut; serClk = 1'b1; tick(3); serClk = 1'b0; tick(3);
    end
    check(serOut == expShift[CODE_W-1], "R12", "serOut unchanged", serOut, expShift[CODE_W-1]);
    sendWord(8'h00); // reads back old word through model check
    commit();

    // R11: parData ignored in serial mode
    parData = 8'hFF; latchEn = 1'b1; tick(4);
    check(activeCode == expCode, "R11", "parData in serial mode", activeCode, expCode);
    latchEn = 1'b0; tick(3); // commit of unchanged shift register
    check(activeCode == expShift, "R11", "code after idle commit", activeCode, expShift);
    expCode = expShift;

    // parallel mode
    serialMode = 1'b0; tick(3);
    parWrite(8'h81);
    parData = 8'h7E; tick(4);
    check(activeCode == 8'h81, "R3", "latch holds", activeCode, 8'h81);
    // R11: serial clocks in parallel mode
    latchEn = 1'b1; parData = 8'h81; tick(3);
    for (int i = 0; i < 4; i++) begin
      serData = 1'b1; serClk = 1'b1; tick(3); serClk = 1'b0; tick(3);
    end
    latchEn = 1'b0; tick(3);
    check(serOut == expShift[CODE_W-1], "R11", "shift reg in parallel mode", serOut, expShift[CODE_W-1]);

    // R9 exact timing, latch transparent
    settleCycles = 16'd10;
    latchEn = 1'b1; tick(3);
    parData = 8'h42; tick(2);
    check(activeCode == 8'h42, "R2", "two-clock follow", activeCode, 8'h42);
    check(codeReady == 0, "R9", "ready drops", codeReady, 0);
    tick(9);
    check(codeReady == 0, "R9", "ready before count", codeReady, 0);
    tick(1);
    check(codeReady == 1, "R9", "ready at count", codeReady, 1);
    // restart on second change
    parData = 8'h43; tick(7);
    parData = 8'h44; tick(2 + 9);
    check(codeReady == 0, "R9", "count restarted", codeReady, 0);
    tick(1);
    check(codeReady == 1, "R9", "ready after restart", codeReady, 1);

    // R10: zero settle
    settleCycles = '0; tick(2);
    parData = 8'h99; tick(2);
    check(codeReady == 1, "R10", "ready stays high", codeReady, 1);
    check(activeCode == 8'h99, "R2", "follow with zero settle", activeCode, 8'h99);
    latchEn = 1'b0; tick(3);
    expCode = 8'h99;

    // random mix
    settleCycles = 16'd4;
    void'($urandom(32'd1234));
    for (int it = 0; it < 40; it++) begin
      logic [CODE_W-1:0] w;
      w = CODE_W'($urandom);
      if ($urandom % 2) begin
        serialMode = 1'b1; tick(3);
        sendWord(w); commit();
      end else begin
        serialMode = 1'b0; tick(3);
        parWrite(w);
      end
      tick(6);
      check(codeReady == 1, "R9", "ready after random write", codeReady, 1);
    end

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule